// File: doc/BRIEF.md
# External Interrupt Sense and Status Flags

This block watches a bank of external interrupt request pins, eight by default, and keeps one sticky status flag per pin. Each pin is first brought into the clock domain through a two-stage synchroniser. A per-line 2-bit sense setting then decides what raises the flag: a low level, a falling edge, a rising edge, or either edge. The flags stay set until something clears them.

Software reaches the flags through a small byte-wide register port. A read returns the current flags. A flag clears only when software writes 0 to it after a read that returned it as 1. Hardware can also clear a flag in two ways. An acknowledge pulse clears it when interrupt entry is taken for that line. A transfer-engine activation pulse clears it when the line's keep bit is 0. A standby clear input wipes every flag at once.

Top module: `ext_irq_flags`

## Requirements
- R1: After reset every flag is 0, and a register read returns 8'h00. Bit n of the register always belongs to request line n.
- R2: While `stby_clr` is high, every flag and every read-arm bit is 0 on the next cycle, whatever set condition is present.
- R3: With sense code 2'b00 (bits [2n+1:2n] of `sense_cfg` for line n), a flag is set while the synchronised pin is low. The flag is visible at most four cycles after the pin falls.
- R4: With sense code 2'b01, a flag is set on a falling edge of the pin. A rising edge or a steady level does not set it.
- R5: With sense code 2'b10, a flag is set on a rising edge of the pin. A falling edge does not set it.
- R6: With sense code 2'b11, a flag is set on either edge of the pin.
- R7: Writing 1 to a flag bit has no effect on that flag.
- R8: A written 0 clears a flag only if a read returned that flag as 1 after it was last set. A 0 written without such a read leaves the flag set. The arm is lost once the flag is cleared by any path.
- R9: In any edge mode, an `ack_pulse` bit clears that line's flag.
- R10: In low-level mode, an `ack_pulse` bit clears the flag only when the synchronised pin is high. While the pin stays low, the flag stays set.
- R11: A `dtc_pulse` bit clears that line's flag when its `dtc_keep` bit is 0. When the keep bit is 1, the pulse has no effect.
- R12: When a set condition and any clear happen in the same cycle, the flag ends up set.
- R13: `reg_rdata` shows the flags when `reg_sel` and `reg_rd` are both high, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stby_clr | input | 1 | Standby clear of all flags, synchronous |
| irq_pin | input | 8 | External request pins, asynchronous |
| sense_cfg | input | 16 | Sense code per line; bits [2n+1:2n] belong to line n |
| ack_pulse | input | 8 | Per-line interrupt-entry acknowledge pulse |
| dtc_pulse | input | 8 | Per-line transfer-engine activation pulse |
| dtc_keep | input | 8 | Per-line bit; when 1, `dtc_pulse` does not clear the flag |
| reg_sel | input | 1 | Register select |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data; a 0 bit requests a clear of that flag |
| reg_rdata | output | 8 | Read data, combinational |

## Verification
Each internal state fault has a distinct signature at the ports:
- A wrong synchroniser or previous-value register either misses an edge or raises a false one. The error shows in the next read, four cycles after the pin moves.
- A stuck or stale arm bit lets an unread 0 write clear a flag, or stops an armed write from clearing it. The register shows this one cycle after the write.
- A flag that takes the wrong clear-versus-set priority reads as 0 while its level condition is still true. A read one cycle after the acknowledge shows this.

The sweeps try every line against every sense code, so a fault confined to one line or one mode is still exposed.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;
endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
    parameter int NUM_LINES   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_i,
    output logic [NUM_LINES-1:0] sync_o,
    output logic [NUM_LINES-1:0] prev_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0][NUM_LINES-1:0] chain;
        logic [NUM_LINES-1:0]                  prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = pin_i;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            s_d.chain[s] = s_q.chain[s-1];
        end
        s_d.prev = s_q.chain[SYNC_STAGES-1];
    end

    // Reset to the idle-high level so that no edge or low level appears after reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.chain[SYNC_STAGES-1];
    assign prev_o = s_q.prev;
endmodule

// File: rtl/irqf_sense.sv
module irqf_sense
    import irqf_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic [NUM_LINES-1:0]   sync_i,
    input  logic [NUM_LINES-1:0]   prev_i,
    input  logic [2*NUM_LINES-1:0] cfg_i,
    output logic [NUM_LINES-1:0]   set_o,
    output logic [NUM_LINES-1:0]   edge_mode_o
);
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        sense_e mode;
        logic   fell, rose;

        assign mode = sense_e'(cfg_i[2*n +: 2]);
        assign fell = prev_i[n] & ~sync_i[n];
        assign rose = ~prev_i[n] & sync_i[n];

        always_comb begin
            unique case (mode)
                SENSE_LOW:  set_o[n] = ~sync_i[n];
                SENSE_FALL: set_o[n] = fell;
                SENSE_RISE: set_o[n] = rose;
                default:    set_o[n] = fell | rose;
            endcase
        end

        assign edge_mode_o[n] = (mode != SENSE_LOW);
    end
endmodule

// File: rtl/irqf_flags.sv
module irqf_flags #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stby_i,
    input  logic [NUM_LINES-1:0] set_i,
    input  logic [NUM_LINES-1:0] edge_mode_i,
    input  logic [NUM_LINES-1:0] sync_i,
    input  logic [NUM_LINES-1:0] ack_i,
    input  logic [NUM_LINES-1:0] dtc_i,
    input  logic [NUM_LINES-1:0] dtc_keep_i,
    input  logic                 rd_hit_i,
    input  logic                 wr_hit_i,
    input  logic [NUM_LINES-1:0] wdata_i,
    output logic [NUM_LINES-1:0] flags_o
);
    typedef struct packed {
        logic [NUM_LINES-1:0] flags;
        logic [NUM_LINES-1:0] arm;
    } flag_t;

    flag_t f_d, f_q;
    logic [NUM_LINES-1:0] clr_sw, clr_ack, clr_dtc, arm_tmp;

    always_comb begin
        clr_sw  = wr_hit_i ? (~wdata_i & f_q.arm) : '0;
        clr_ack = ack_i & (edge_mode_i | sync_i);
        clr_dtc = dtc_i & ~dtc_keep_i;
        f_d.flags = set_i | (f_q.flags & ~(clr_sw | clr_ack | clr_dtc));
        arm_tmp = f_q.arm & ~clr_sw;
        if (rd_hit_i) arm_tmp = arm_tmp | f_q.flags;
        f_d.arm = arm_tmp & f_d.flags;
        if (stby_i) f_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flags_o = f_q.flags;

    // Port-level view of what may legally clear a flag; the arm and mode qualifiers are left out.
    logic [NUM_LINES-1:0] may_clear;
    assign may_clear = ack_i | (dtc_i & ~dtc_keep_i) | (wr_hit_i ? ~wdata_i : '0)
                     | {NUM_LINES{stby_i}};

    assert_standby_wipe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stby_i |=> (f_q == '0));

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!stby_i && set_i != '0) |=> ((f_q.flags & $past(set_i)) == $past(set_i)));

    assert_fall_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(f_q.flags) & ~f_q.flags) & ~$past(may_clear)) == '0));

    assert_arm_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.arm & ~f_q.flags) == '0);
endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags #(
    parameter int NUM_LINES   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stby_clr,
    input  logic [NUM_LINES-1:0]   irq_pin,
    input  logic [2*NUM_LINES-1:0] sense_cfg,
    input  logic [NUM_LINES-1:0]   ack_pulse,
    input  logic [NUM_LINES-1:0]   dtc_pulse,
    input  logic [NUM_LINES-1:0]   dtc_keep,
    input  logic                   reg_sel,
    input  logic                   reg_rd,
    input  logic                   reg_wr,
    input  logic [NUM_LINES-1:0]   reg_wdata,
    output logic [NUM_LINES-1:0]   reg_rdata
);
    logic [NUM_LINES-1:0] pin_sync, pin_prev, set_vec, edge_mode, flags;
    logic rd_hit, wr_hit;

    assign rd_hit = reg_sel & reg_rd;
    assign wr_hit = reg_sel & reg_wr;

    irqf_sync #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(irq_pin), .sync_o(pin_sync), .prev_o(pin_prev)
    );

    irqf_sense #(.NUM_LINES(NUM_LINES)) u_sense (
        .sync_i(pin_sync), .prev_i(pin_prev), .cfg_i(sense_cfg),
        .set_o(set_vec), .edge_mode_o(edge_mode)
    );

    irqf_flags #(.NUM_LINES(NUM_LINES)) u_flags (
        .clk(clk), .rst_n(rst_n), .stby_i(stby_clr), .set_i(set_vec),
        .edge_mode_i(edge_mode), .sync_i(pin_sync), .ack_i(ack_pulse),
        .dtc_i(dtc_pulse), .dtc_keep_i(dtc_keep), .rd_hit_i(rd_hit),
        .wr_hit_i(wr_hit), .wdata_i(reg_wdata), .flags_o(flags)
    );

    assign reg_rdata = rd_hit ? flags : '0;
endmodule

// File: tb/sim_ext_irq_flags.sv
module sim_ext_irq_flags;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stby_clr = 1'b0;
    logic [7:0]  irq_pin = 8'hFF;
    logic [15:0] sense_cfg = 16'h5555;
    logic [7:0]  ack_pulse = '0, dtc_pulse = '0, dtc_keep = '0;
    logic        reg_sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    int total = 0, bad = 0;
    logic [7:0] v;

    always #10 clk = ~clk;

    ext_irq_flags u0 (
        .clk(clk), .rst_n(rst_n), .stby_clr(stby_clr), .irq_pin(irq_pin),
        .sense_cfg(sense_cfg), .ack_pulse(ack_pulse), .dtc_pulse(dtc_pulse),
        .dtc_keep(dtc_keep), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic rd(output logic [7:0] val);
        reg_sel = 1'b1; reg_rd = 1'b1;
        #1 val = reg_rdata;
        @(negedge clk);
        reg_sel = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic wipe();
        stby_clr = 1'b1;
        @(negedge clk);
        stby_clr = 1'b0;
    endtask

    task automatic pin_to(input int n, input logic lvl);
        irq_pin[n] = lvl;
        cyc(4);
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(4);
        rd(v); chk("R1 reset value", v, 8'h00);

        // Sweep: every line against every sense code
        for (int n = 0; n < 8; n++) begin
            for (int m = 0; m < 4; m++) begin
                wipe();
                sense_cfg = 16'h5555;
                sense_cfg[2*n +: 2] = m[1:0];
                cyc(4);
                rd(v); chk("R13 idle read", v, 8'h00);
                pin_to(n, 1'b0);
                rd(v);
                chk(m == 0 ? "R3 low level" : m == 1 ? "R4 falling" : m == 2 ? "R5 no set on fall"
                           : "R6 fall", v, (m == 2) ? 8'h00 : (8'h01 << n));
                pin_to(n, 1'b1);
                rd(v);
                chk(m == 0 ? "R3 sticky" : m == 1 ? "R4 no clear on rise" : m == 2 ? "R5 rising"
                           : "R6 rise", v, 8'h01 << n);
                wr(8'h00);
                rd(v); chk("R8 armed clear", v, 8'h00);
            end
        end

        // R7: a written 1 has no effect on the flag
        wipe(); sense_cfg = 16'h5555;
        pin_to(3, 1'b0); pin_to(3, 1'b1);
        rd(v); wr(8'hFF);
        rd(v); chk("R7 write one", v, 8'h08);
        wr(8'h00);
        rd(v); chk("R8 clear after read", v, 8'h00);

        // R8: a 0 write without a prior read, and a stale arm after a hardware clear
        pin_to(2, 1'b0); pin_to(2, 1'b1);
        wr(8'h00);
        rd(v); chk("R8 unarmed write", v, 8'h04);
        ack_pulse = 8'h04; @(negedge clk); ack_pulse = '0;
        pin_to(2, 1'b0); pin_to(2, 1'b1);
        wr(8'h00);
        rd(v); chk("R8 arm lost after ack", v, 8'h04);
        wipe();

        // R13: read data is 0 when no read strobe is present
        pin_to(4, 1'b0); pin_to(4, 1'b1);
        #1 chk("R13 no strobe", reg_rdata, 8'h00);
        wipe();

        // R9: acknowledge in an edge mode
        sense_cfg[11:10] = 2'b10;
        pin_to(5, 1'b0); pin_to(5, 1'b1);
        rd(v); chk("R5 set before ack", v, 8'h20);
        ack_pulse = 8'h20; @(negedge clk); ack_pulse = '0;
        rd(v); chk("R9 edge ack", v, 8'h00);

        // R10 and R12: acknowledge in low-level mode
        wipe(); sense_cfg = 16'h5555; sense_cfg[3:2] = 2'b00;
        pin_to(1, 1'b0);
        ack_pulse = 8'h02; @(negedge clk); ack_pulse = '0;
        rd(v); chk("R10 ack while low", v, 8'h02);
        wr(8'h00);
        rd(v); chk("R12 set beats write", v, 8'h02);
        pin_to(1, 1'b1);
        ack_pulse = 8'h02; @(negedge clk); ack_pulse = '0;
        rd(v); chk("R10 ack while high", v, 8'h00);

        // R11: transfer-engine pulse with and without the keep bit
        wipe(); sense_cfg = 16'h5555;
        pin_to(6, 1'b0); pin_to(6, 1'b1);
        dtc_keep = 8'h40; dtc_pulse = 8'h40; @(negedge clk); dtc_pulse = '0;
        rd(v); chk("R11 keep set", v, 8'h40);
        dtc_keep = 8'h00; dtc_pulse = 8'h40; @(negedge clk); dtc_pulse = '0;
        rd(v); chk("R11 keep clear", v, 8'h00);

        // R2: standby clear wins over a live level condition
        sense_cfg = 16'h0000;
        pin_to(0, 1'b0);
        irq_pin[7] = 1'b0; cyc(4);
        rd(v); chk("R3 two lines", v, 8'h81);
        wipe();
        rd(v); chk("R2 standby", v, 8'h00);
        irq_pin = 8'hFF; cyc(4); wipe();
        rd(v); chk("R2 after release", v, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule